// File: doc/BRIEF.md
# Receive FIFO Pause Flow Controller

This block decides when the receive side of an Ethernet MAC asks the link partner to stop or resume sending. It watches how full the receive FIFO is. The occupancy arrives in bytes and is reduced to 64-byte units. The reduced value is compared against two programmable levels with hysteresis between them. When the FIFO reaches the upper level, the block queues a stop request (XOFF) that carries a programmable pause time. When the FIFO drains to the lower level after a stop, it queues a resume request (XON) with a pause time of zero. Software can also queue its own pause request with any pause time. All requests leave on one valid/ready stream toward the frame builder.

The block also keeps the 16-bit pause timer. A pause frame received from the partner loads the timer with its pause time. Each slot-time tick then counts the timer down to zero. While the timer is nonzero the transmit side is held off. The block also exposes two constants that its neighbours need:
- the MAC control frame type, 0x8808;
- the FIFO size in 64-byte units, which software uses to choose the thresholds.

Back-pressure works as follows. The request stream holds its item stable until `pause_req_ready` accepts it. Only one item waits in the output register. Behind it, at most one stop-or-resume request and one software request can be parked. The software command input is a valid/ready port with a single holding slot. `sw_pause_ready` is low while a software command is parked. The received-pause event, the slot tick and the occupancy are plain control inputs, and they are never back-pressured.

Top module: `rx_pause_flow_ctrl`

## Requirements
- R1: After reset, `pause_timer` is 0, `tx_hold` is 0, `pause_req_valid` is 0 and `sw_pause_ready` is 1.
- R2: The occupancy in units is floor(`occ_bytes`/64). When no stop is in force and units >= `off_thresh`, exactly one request is queued with kind 1 (XOFF) and quanta `xoff_quanta`. No further XOFF is queued until a resume crossing has occurred.
- R3: While a stop is in force, units <= `on_thresh` ends it and queues exactly one request of kind 2 (XON) with quanta 0. No XON is queued when no stop is in force.
- R4: If a crossing occurs while the request of the opposite kind is still parked and has not entered the output register, the two cancel and neither is emitted.
- R5: While `pause_req_valid` is high and `pause_req_ready` is low, `pause_req_valid`, `pause_req_kind` and `pause_req_quanta` stay unchanged. Each handshake delivers one request.
- R6: When a stop/resume request and a software request are both parked, the stop/resume request enters the output register first.
- R7: A software command is taken when `sw_pause_valid` and `sw_pause_ready` are both high. It is emitted with kind 3 and its own quanta. `sw_pause_ready` stays low while a taken command is still parked.
- R8: A cycle with `rx_pause_valid` high loads `pause_timer` with `rx_pause_quanta`, taking precedence over a tick. A quanta of 0 clears the timer at once.
- R9: Each `slot_tick` without a load lowers a nonzero `pause_timer` by one. At zero the timer stays at zero. `tx_hold` is high exactly when the timer is nonzero.
- R10: `mac_ctrl_type` reads 0x8808, and `fifo_size_units` reads FIFO_BYTES/64 (128 with defaults).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| occ_bytes | input | OCC_W | Receive FIFO occupancy in bytes |
| off_thresh | input | THR_W | Stop level in 64-byte units |
| on_thresh | input | THR_W | Resume level in 64-byte units |
| xoff_quanta | input | QUANTA_W | Pause time carried by stop requests |
| rx_pause_valid | input | 1 | Pulse: a pause frame was received |
| rx_pause_quanta | input | QUANTA_W | Pause time of the received frame |
| slot_tick | input | 1 | One pulse per slot time |
| sw_pause_valid | input | 1 | Software pause command offered |
| sw_pause_ready | output | 1 | Software command slot is free |
| sw_pause_quanta | input | QUANTA_W | Pause time of the software command |
| pause_req_valid | output | 1 | Pause request available |
| pause_req_ready | input | 1 | Frame builder takes the request |
| pause_req_kind | output | 2 | 1 XOFF, 2 XON, 3 software |
| pause_req_quanta | output | QUANTA_W | Pause time to place in the frame |
| tx_hold | output | 1 | Transmit held off by the partner's pause |
| pause_timer | output | QUANTA_W | Current pause timer value |
| mac_ctrl_type | output | 16 | MAC control frame type constant |
| fifo_size_units | output | THR_W | FIFO size in 64-byte units |

## Verification
The assertions check four things on every cycle. A stop or resume state change must follow a real threshold crossing. The request stream must stay stable under back-pressure. A parked stop/resume request must beat a software one. The timer must load on received pauses and count down on ticks. Only the bench scenarios can show the following, because they depend on whole sequences:
- one request per crossing, however long the level stays over the threshold;
- cancellation of an unsent stop by a quick drain;
- the exact order of items when several wait behind a stalled consumer;
- saturation of the timer at zero.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int UNIT_SHIFT = 6;
  localparam logic [15:0] MAC_CTRL_TYPE = 16'h8808;

  typedef enum logic [1:0] {
    REQ_NONE = 2'd0,
    REQ_XOFF = 2'd1,
    REQ_XON  = 2'd2,
    REQ_SW   = 2'd3
  } req_kind_e;
endpackage

// File: rtl/pfc_level_mon.sv
module pfc_level_mon #(
  parameter int OCC_W = 16,
  parameter int THR_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] occ_bytes,
  input  logic [THR_W-1:0] off_thr,
  input  logic [THR_W-1:0] on_thr,
  output logic             xoff_evt,
  output logic             xon_evt,
  output logic             stop_active
);
  import pfc_pkg::*;
  localparam int UNITS_W = OCC_W - UNIT_SHIFT;
  localparam int CMP_W   = (UNITS_W > THR_W) ? UNITS_W : THR_W;

  logic [CMP_W-1:0] units, off_c, on_c;
  logic             at_or_above_off, at_or_below_on;

  always_comb begin
    units = '0;
    off_c = '0;
    on_c  = '0;
    units[UNITS_W-1:0] = occ_bytes[OCC_W-1:UNIT_SHIFT];
    off_c[THR_W-1:0]   = off_thr;
    on_c[THR_W-1:0]    = on_thr;
  end

  assign at_or_above_off = (units >= off_c);
  assign at_or_below_on  = (units <= on_c);

  // hysteresis: one event per crossing in each direction
  assign xoff_evt = !stop_active && at_or_above_off;
  assign xon_evt  = stop_active && at_or_below_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stop_active <= 1'b0;
    else if (xoff_evt) stop_active <= 1'b1;
    else if (xon_evt)  stop_active <= 1'b0;
  end

  assert_stop_on_crossing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_active) |-> $past(at_or_above_off));
  assert_resume_on_crossing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_active) |-> $past(at_or_below_on));
endmodule

// File: rtl/pfc_req_arb.sv
module pfc_req_arb #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xoff_evt,
  input  logic          xon_evt,
  input  logic [QW-1:0] xoff_quanta,
  input  logic          sw_valid,
  output logic          sw_ready,
  input  logic [QW-1:0] sw_quanta,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [1:0]    req_kind,
  output logic [QW-1:0] req_quanta
);
  import pfc_pkg::*;

  logic          xoff_pend, xon_pend, sw_pend;
  logic [QW-1:0] xoff_q, sw_q;
  logic          out_load, hw_pend, take_hw, take_sw;
  logic          xoff_taking, xon_taking;
  logic          xoff_pend_d, xon_pend_d;

  assign out_load    = !req_valid || req_ready;
  assign hw_pend     = xoff_pend || xon_pend;
  assign take_hw     = out_load && hw_pend;
  assign take_sw     = out_load && !hw_pend && sw_pend;
  assign xoff_taking = take_hw && xoff_pend;
  assign xon_taking  = take_hw && !xoff_pend && xon_pend;
  assign sw_ready    = !sw_pend;

  // opposite-kind crossings cancel an entry that has not reached the output
  always_comb begin
    xoff_pend_d = xoff_pend;
    if (xoff_evt)                    xoff_pend_d = !(xon_pend && !xon_taking);
    else if (xoff_taking || xon_evt) xoff_pend_d = 1'b0;
    xon_pend_d = xon_pend;
    if (xon_evt)                     xon_pend_d = !(xoff_pend && !xoff_taking);
    else if (xon_taking || xoff_evt) xon_pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xoff_pend <= 1'b0;
      xon_pend  <= 1'b0;
      xoff_q    <= '0;
    end else begin
      xoff_pend <= xoff_pend_d;
      xon_pend  <= xon_pend_d;
      if (xoff_evt) xoff_q <= xoff_quanta;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_pend <= 1'b0;
      sw_q    <= '0;
    end else if (sw_valid && sw_ready) begin
      sw_pend <= 1'b1;
      sw_q    <= sw_quanta;
    end else if (take_sw) begin
      sw_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid  <= 1'b0;
      req_kind   <= REQ_NONE;
      req_quanta <= '0;
    end else if (out_load) begin
      req_valid <= take_hw || take_sw;
      if (xoff_taking) begin
        req_kind   <= REQ_XOFF;
        req_quanta <= xoff_q;
      end else if (xon_taking) begin
        req_kind   <= REQ_XON;
        req_quanta <= '0;
      end else if (take_sw) begin
        req_kind   <= REQ_SW;
        req_quanta <= sw_q;
      end else begin
        req_kind   <= REQ_NONE;
      end
    end
  end

  assert_hold_under_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_kind) && $stable(req_quanta)));
  assert_hw_before_sw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_load && hw_pend && sw_pend) |=> (req_kind != REQ_SW));
endmodule

// File: rtl/pfc_pause_timer.sv
module pfc_pause_timer #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [QW-1:0] load_val,
  input  logic          tick,
  output logic [QW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    count <= '0;
    else if (load)                 count <= load_val;
    else if (tick && count != '0)  count <= count - 1'b1;
  end

  assert_timer_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));
  assert_timer_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && count != '0) |=> (count == $past(count) - 1'b1));
  assert_timer_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count == '0) |=> (count == '0));
endmodule

// File: rtl/rx_pause_flow_ctrl.sv
module rx_pause_flow_ctrl #(
  parameter int OCC_W      = 16,
  parameter int THR_W      = 11,
  parameter int QUANTA_W   = 16,
  parameter int FIFO_BYTES = 8192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [OCC_W-1:0]    occ_bytes,
  input  logic [THR_W-1:0]    off_thresh,
  input  logic [THR_W-1:0]    on_thresh,
  input  logic [QUANTA_W-1:0] xoff_quanta,
  input  logic                rx_pause_valid,
  input  logic [QUANTA_W-1:0] rx_pause_quanta,
  input  logic                slot_tick,
  input  logic                sw_pause_valid,
  output logic                sw_pause_ready,
  input  logic [QUANTA_W-1:0] sw_pause_quanta,
  output logic                pause_req_valid,
  input  logic                pause_req_ready,
  output logic [1:0]          pause_req_kind,
  output logic [QUANTA_W-1:0] pause_req_quanta,
  output logic                tx_hold,
  output logic [QUANTA_W-1:0] pause_timer,
  output logic [15:0]         mac_ctrl_type,
  output logic [THR_W-1:0]    fifo_size_units
);
  import pfc_pkg::*;
  localparam int UNITS = FIFO_BYTES >> UNIT_SHIFT;
  localparam logic [THR_W-1:0] UNITS_V = THR_W'(UNITS);

  logic xoff_evt, xon_evt, stop_active;

  pfc_level_mon #(.OCC_W(OCC_W), .THR_W(THR_W)) u_level (
    .clk(clk), .rst_n(rst_n), .occ_bytes(occ_bytes),
    .off_thr(off_thresh), .on_thr(on_thresh),
    .xoff_evt(xoff_evt), .xon_evt(xon_evt), .stop_active(stop_active)
  );

  pfc_req_arb #(.QW(QUANTA_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .xoff_evt(xoff_evt), .xon_evt(xon_evt),
    .xoff_quanta(xoff_quanta), .sw_valid(sw_pause_valid), .sw_ready(sw_pause_ready),
    .sw_quanta(sw_pause_quanta), .req_valid(pause_req_valid), .req_ready(pause_req_ready),
    .req_kind(pause_req_kind), .req_quanta(pause_req_quanta)
  );

  pfc_pause_timer #(.QW(QUANTA_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(rx_pause_valid), .load_val(rx_pause_quanta),
    .tick(slot_tick), .count(pause_timer)
  );

  assign tx_hold         = (pause_timer != '0);
  assign mac_ctrl_type   = MAC_CTRL_TYPE;
  assign fifo_size_units = UNITS_V;
endmodule

// File: tb/rx_pause_flow_ctrl_tb_top.sv
module rx_pause_flow_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] occ_bytes = '0;
  logic [10:0] off_thresh = 11'd10, on_thresh = 11'd4;
  logic [15:0] xoff_quanta = 16'h1234;
  logic        rx_pause_valid = 1'b0;
  logic [15:0] rx_pause_quanta = '0;
  logic        slot_tick = 1'b0;
  logic        sw_pause_valid = 1'b0;
  logic        sw_pause_ready;
  logic [15:0] sw_pause_quanta = '0;
  logic        pause_req_valid;
  logic        pause_req_ready = 1'b0;
  logic [1:0]  pause_req_kind;
  logic [15:0] pause_req_quanta;
  logic        tx_hold;
  logic [15:0] pause_timer;
  logic [15:0] mac_ctrl_type;
  logic [10:0] fifo_size_units;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [17:0] exp_q[$];

  always #2 clk = ~clk;

  rx_pause_flow_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .occ_bytes(occ_bytes), .off_thresh(off_thresh),
    .on_thresh(on_thresh), .xoff_quanta(xoff_quanta), .rx_pause_valid(rx_pause_valid),
    .rx_pause_quanta(rx_pause_quanta), .slot_tick(slot_tick),
    .sw_pause_valid(sw_pause_valid), .sw_pause_ready(sw_pause_ready),
    .sw_pause_quanta(sw_pause_quanta), .pause_req_valid(pause_req_valid),
    .pause_req_ready(pause_req_ready), .pause_req_kind(pause_req_kind),
    .pause_req_quanta(pause_req_quanta), .tx_hold(tx_hold), .pause_timer(pause_timer),
    .mac_ctrl_type(mac_ctrl_type), .fifo_size_units(fifo_size_units)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_req(input logic [1:0] kind, input logic [15:0] q);
    exp_q.push_back({kind, q});
  endtask

  task automatic sw_send(input logic [15:0] q);
    @(negedge clk);
    sw_pause_valid = 1'b1;
    sw_pause_quanta = q;
    while (!sw_pause_ready) @(negedge clk);
    @(negedge clk);
    sw_pause_valid = 1'b0;
  endtask

  // monitor: samples 1 ns after the falling edge, ahead of the next rising edge
  always begin
    @(negedge clk);
    #1;
    if (rst_n && pause_req_valid && pause_req_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R3 unexpected request", {14'd0, pause_req_kind, pause_req_quanta}, 32'h0);
      end else begin
        logic [17:0] e;
        e = exp_q.pop_front();
        check({pause_req_kind, pause_req_quanta} == e, "R2/R3/R6/R7 request order",
              {14'd0, pause_req_kind, pause_req_quanta}, {14'd0, e});
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state, R10 constants
    check(pause_timer == 16'd0, "R1 timer", pause_timer, 0);
    check(tx_hold == 1'b0, "R1 hold", tx_hold, 0);
    check(pause_req_valid == 1'b0, "R1 req_valid", pause_req_valid, 0);
    check(sw_pause_ready == 1'b1, "R1 sw_ready", sw_pause_ready, 1);
    check(mac_ctrl_type == 16'h8808, "R10 type", mac_ctrl_type, 32'h8808);
    check(fifo_size_units == 11'd128, "R10 size", fifo_size_units, 128);

    // R2 / R3 basic hysteresis
    pause_req_ready = 1'b1;
    occ_bytes = 16'd639; step(5);
    occ_bytes = 16'd640; expect_req(2'd1, 16'h1234); step(10);
    occ_bytes = 16'd700; step(10);
    occ_bytes = 16'd320; step(10);
    occ_bytes = 16'd300; expect_req(2'd2, 16'h0000); step(10);
    occ_bytes = 16'd100; step(5);

    // R7 software command
    expect_req(2'd3, 16'h0055);
    sw_send(16'h0055); step(5);

    // R5 / R6 / R7 with a stalled consumer
    pause_req_ready = 1'b0;
    expect_req(2'd3, 16'h0077);
    sw_send(16'h0077);
    sw_send(16'h0088);
    check(sw_pause_ready == 1'b0, "R7 sw_ready low while parked", sw_pause_ready, 0);
    occ_bytes = 16'd800; step(3);
    expect_req(2'd1, 16'h1234);
    expect_req(2'd3, 16'h0088);
    check(pause_req_valid && pause_req_kind == 2'd3 && pause_req_quanta == 16'h0077,
          "R5 held item", {15'd0, pause_req_valid, pause_req_quanta}, {15'd1, 16'h0077});
    step(4);
    check(pause_req_valid && pause_req_kind == 2'd3 && pause_req_quanta == 16'h0077,
          "R5 still held", {15'd0, pause_req_valid, pause_req_quanta}, {15'd1, 16'h0077});
    pause_req_ready = 1'b1; step(10);
    occ_bytes = 16'd100; expect_req(2'd2, 16'h0000); step(10);

    // R4 cancellation of an unsent XOFF
    pause_req_ready = 1'b0;
    expect_req(2'd3, 16'h0099);
    sw_send(16'h0099);
    occ_bytes = 16'd800; step(3);
    occ_bytes = 16'd100; step(3);
    pause_req_ready = 1'b1; step(10);
    check(pause_req_valid == 1'b0, "R4 nothing after cancel", pause_req_valid, 0);
    occ_bytes = 16'd800; expect_req(2'd1, 16'h1234); step(10);
    occ_bytes = 16'd100; expect_req(2'd2, 16'h0000); step(10);

    // R8 / R9 pause timer
    rx_pause_valid = 1'b1; rx_pause_quanta = 16'd3; step(1);
    rx_pause_valid = 1'b0;
    check(pause_timer == 16'd3, "R8 load", pause_timer, 3);
    check(tx_hold == 1'b1, "R9 hold while nonzero", tx_hold, 1);
    step(3);
    check(pause_timer == 16'd3, "R9 no tick no change", pause_timer, 3);
    for (int i = 2; i >= 0; i--) begin
      slot_tick = 1'b1; step(1); slot_tick = 1'b0;
      check(pause_timer == 16'(i), "R9 decrement", pause_timer, i);
    end
    check(tx_hold == 1'b0, "R9 hold released", tx_hold, 0);
    slot_tick = 1'b1; step(1); slot_tick = 1'b0;
    check(pause_timer == 16'd0, "R9 floor at zero", pause_timer, 0);
    rx_pause_valid = 1'b1; rx_pause_quanta = 16'd500; step(1);
    rx_pause_quanta = 16'd0; step(1);
    rx_pause_valid = 1'b0;
    check(pause_timer == 16'd0, "R8 zero quanta clears", pause_timer, 0);
    rx_pause_valid = 1'b1; rx_pause_quanta = 16'd2; slot_tick = 1'b1; step(1);
    rx_pause_valid = 1'b0; slot_tick = 1'b0;
    check(pause_timer == 16'd2, "R8 load beats tick", pause_timer, 2);

    step(5);
    check(exp_q.size() == 0, "R2/R3 all expected requests seen", exp_q.size(), 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule